// File: doc/BRIEF.md
# Prescaled Trigger-Controlled Timebase Counter

This block is the shared timebase of a timer. A two-bit clock-mode input chooses what advances the counter: nothing, every cycle of the system clock, or rising edges of an external clock that is brought into the system clock domain by a two-stage synchronizer. The chosen tick then passes through a power-of-two prescaler, and the counter climbs from 0 to a programmable modulo before it wraps to 0 and raises a sticky overflow flag. The flag has its own interrupt mask and is cleared by a write-one pulse.

One of several trigger inputs is selected. Its polarity is adjusted first, and it is then synchronized and edge-detected. The trigger can hold the counter idle until its first active edge, reload the counter on every active edge, or freeze counting while its active level is held. Further controls make the counter halt at 0 after its first overflow, freeze while the chip is in debug unless a run-in-debug control is set, and freeze in a low-power doze state when that behaviour is enabled. A registered copy of the clock mode lets software poll until it reads 0, which confirms that the counter has stopped.

Top module: `trig_timebase`

## Requirements
- R1: The readback `clk_mode_rb` equals the `clk_mode` value of the previous clock edge. While the readback is 0 (off) or 3 (reserved), the count does not change.
- R2: In mode 1 (system clock) with prescale code p (0..7, dividing by 2^p), the counter advances once every 2^p cycles, so consecutive wraps are (modulo+1)*2^p cycles apart.
- R3: In mode 2 (external clock), the counter advances once every 2^p synchronized rising edges of `ext_clk_in`.
- R4: The count runs from 0 to `modulo`, wraps to 0 on the tick after it reaches `modulo`, and never steps by more than one except to 0.
- R5: A wrap sets `ovf_flag`. The flag stays set until an `ovf_clear` pulse, and a wrap in the same cycle wins over the clear. `ovf_irq` is the flag gated by `ovf_irq_en`.
- R6: With `start_on_trig` set, a counter that has just been enabled holds its value until the first active trigger edge.
- R7: With `reload_on_trig` set, an active trigger edge forces the count to 0 three edges after the trigger is driven, and counting then resumes at once.
- R8: With `pause_on_trig` set, counting halts while the synchronized trigger level is active.
- R9: `trig_sel` chooses which `trig_in` bit is used, and the other bits have no effect. With `trig_active_low` set, a low input level counts as active.
- R10: With `stop_on_ovf` set, the counter halts at 0 after its first wrap. It runs again only after the mode has gone to 0 and back.
- R11: While `dbg_mode` is high, counting halts unless `dbg_run` is high.
- R12: While `doze_mode` is high, counting halts if `doze_pause` is high and continues otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_mode | input | 2 | 0 off, 1 system clock, 2 external clock, 3 reserved (off) |
| clk_mode_rb | output | 2 | Registered clock mode, 0 confirms stop |
| prescale | input | 3 | Divide the tick by 2^prescale |
| modulo | input | CNT_W | Terminal count |
| ext_clk_in | input | 1 | External count clock, asynchronous |
| trig_in | input | N_TRIG | Trigger candidates, asynchronous |
| trig_sel | input | SEL_W | Trigger select |
| trig_active_low | input | 1 | Invert the selected trigger |
| start_on_trig | input | 1 | Wait for the first trigger edge before counting |
| reload_on_trig | input | 1 | Zero the count on each trigger edge |
| pause_on_trig | input | 1 | Freeze while the trigger is active |
| stop_on_ovf | input | 1 | Halt after the first wrap |
| dbg_mode | input | 1 | Chip is in debug |
| dbg_run | input | 1 | Keep counting in debug |
| doze_mode | input | 1 | Chip is in doze |
| doze_pause | input | 1 | Freeze in doze |
| ovf_clear | input | 1 | Write-one clear pulse for the flag |
| ovf_irq_en | input | 1 | Overflow interrupt mask |
| count | output | CNT_W | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Masked overflow interrupt |

## Verification
The properties assume that `clk_mode` is held at 0 throughout reset and that the count starts each run no higher than `modulo`. When `modulo` changes, the bound on the count is checked only after the count has been back inside the new range. The bench changes `modulo` and `prescale` only while the mode is 0, and drops the first wrap of every run before it measures periods. It keeps the trigger level steady whenever it changes `trig_active_low`, so that a change of polarity does not produce a trigger edge.

// File: rtl/tbase_pkg.sv
// Shared types for the timebase: clock-mode encoding and divider helper.
// Assumes the prescale field is narrow enough (<= 4 bits) to make the
// divider width small.
package tbase_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_SYS  = 2'd1,
        MODE_EXT  = 2'd2,
        MODE_RSVD = 2'd3
    } clk_mode_e;

    // Width of the free-running divider for a given prescale field width.
    function automatic int div_width(input int ps_w);
        return (1 << ps_w) - 1;
    endfunction

endpackage

// File: rtl/tbase_clk_src.sv
// Clock qualification and prescaler.
// Produces a single-cycle count enable in the system clock domain. The
// external clock is synchronized and its rising edges are turned into
// ticks; the system-clock mode ticks every cycle. A free-running divider
// with a prescale mask passes one tick in 2^prescale.
// Assumes ext_clk_in is at most a quarter of the system clock rate.
module tbase_clk_src #(
    parameter int PS_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_q,
    input  logic [PS_W-1:0] prescale,
    input  logic            ext_clk_in,
    input  logic            advance,
    input  logic            restart,
    output logic            cnt_tick
);
    import tbase_pkg::*;

    localparam int DIV_W = div_width(PS_W);

    logic [SYNC_STAGES:0] ext_sh;
    logic                 ext_rise;
    logic                 src_tick;
    logic [DIV_W-1:0]     div_cnt;
    logic [DIV_W-1:0]     div_mask;
    clk_mode_e            mode_e;

    assign mode_e = clk_mode_e'(mode_q);

    // Synchronize the external clock and keep one extra stage for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sh <= '0;
        else        ext_sh <= {ext_sh[SYNC_STAGES-1:0], ext_clk_in};
    end

    assign ext_rise = ext_sh[SYNC_STAGES-1] & ~ext_sh[SYNC_STAGES];

    // Pick the raw tick source from the registered mode.
    always_comb begin
        case (mode_e)
            MODE_SYS: src_tick = 1'b1;
            MODE_EXT: src_tick = ext_rise;
            default:  src_tick = 1'b0;
        endcase
    end

    // Build the low-bit mask that selects the division ratio.
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            div_mask[i] = (i < int'(prescale));
        end
    end

    // Advance the divider on qualified source ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                   div_cnt <= '0;
        else if (restart)             div_cnt <= '0;
        else if (src_tick && advance) div_cnt <= div_cnt + DIV_W'(1);
    end

    assign cnt_tick = src_tick & advance & ((div_cnt & div_mask) == div_mask);

endmodule

// File: rtl/tbase_trig_cond.sv
// Trigger conditioning.
// Selects one trigger input and applies the polarity before a synchronizer,
// then supplies the synchronized active level and a one-cycle active edge.
// Assumes the trigger is held for at least two system clock cycles.
module tbase_trig_cond #(
    parameter int N_TRIG      = 4,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic              active_low,
    output logic              trig_level,
    output logic              trig_edge
);
    logic                 picked;
    logic [SYNC_STAGES:0] trig_sh;

    // Choose the trigger and turn it into active-high form.
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < N_TRIG; i++) begin
            if (int'(trig_sel) == i) picked = trig_in[i];
        end
        picked = picked ^ active_low;
    end

    // Synchronize the active-high trigger, plus one stage for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_sh <= '0;
        else        trig_sh <= {trig_sh[SYNC_STAGES-1:0], picked};
    end

    assign trig_level = trig_sh[SYNC_STAGES-1];
    assign trig_edge  = trig_sh[SYNC_STAGES-1] & ~trig_sh[SYNC_STAGES];

endmodule

// File: rtl/tbase_count_core.sv
// Counter core.
// Holds the count, the start and halt state and the overflow flag. Decides
// whether the prescaler may advance, and applies reloads and wraps.
// Assumes cnt_tick is high only in cycles where advance is high.
module tbase_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_q,
    input  logic [CNT_W-1:0] modulo,
    input  logic             cnt_tick,
    input  logic             trig_level,
    input  logic             trig_edge,
    input  logic             start_on_trig,
    input  logic             reload_on_trig,
    input  logic             pause_on_trig,
    input  logic             stop_on_ovf,
    input  logic             dbg_mode,
    input  logic             dbg_run,
    input  logic             doze_mode,
    input  logic             doze_pause,
    input  logic             ovf_clear,
    input  logic             ovf_irq_en,
    output logic             advance,
    output logic             restart,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag,
    output logic             ovf_irq
);
    import tbase_pkg::*;

    clk_mode_e mode_e;
    logic      run_en;
    logic      started;
    logic      halted;
    logic      pause_now;
    logic      reload_hit;
    logic      wrap;

    assign mode_e     = clk_mode_e'(mode_q);
    assign run_en     = (mode_e == MODE_SYS) || (mode_e == MODE_EXT);
    assign reload_hit = run_en & reload_on_trig & trig_edge;
    assign restart    = reload_hit | ~run_en;
    assign pause_now  = (pause_on_trig & trig_level)
                      | (dbg_mode & ~dbg_run)
                      | (doze_mode & doze_pause);
    assign advance    = run_en & started & ~halted & ~pause_now;
    assign wrap       = cnt_tick & (count >= modulo);

    // Arm the counter: right away, or on the first trigger edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en)                 started <= 1'b0;
        else if (!start_on_trig || trig_edge)  started <= 1'b1;
    end

    // Latch a halt after the first wrap when stop-on-overflow is on.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en)      halted <= 1'b0;
        else if (wrap && stop_on_ovf) halted <= 1'b1;
    end

    // Count, wrap at the modulo, or reload on a trigger edge.
    always_ff @(posedge clk) begin
        if (!rst_n)          count <= '0;
        else if (reload_hit) count <= '0;
        else if (wrap)       count <= '0;
        else if (cnt_tick)   count <= count + CNT_W'(1);
    end

    // Sticky overflow flag; a new wrap wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         ovf_flag <= 1'b0;
        else if (wrap)      ovf_flag <= 1'b1;
        else if (ovf_clear) ovf_flag <= 1'b0;
    end

    assign ovf_irq = ovf_flag & ovf_irq_en;

endmodule

// File: rtl/trig_timebase.sv
// Timebase top: clock-mode register, clock qualification with prescaler,
// trigger conditioning and counter core.
// Assumes all control inputs are synchronous to clk except ext_clk_in and
// trig_in, which are synchronized inside.
module trig_timebase #(
    parameter int CNT_W       = 16,
    parameter int PS_W        = 3,
    parameter int N_TRIG      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        clk_mode,
    output logic [1:0]        clk_mode_rb,
    input  logic [PS_W-1:0]   prescale,
    input  logic [CNT_W-1:0]  modulo,
    input  logic              ext_clk_in,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic              trig_active_low,
    input  logic              start_on_trig,
    input  logic              reload_on_trig,
    input  logic              pause_on_trig,
    input  logic              stop_on_ovf,
    input  logic              dbg_mode,
    input  logic              dbg_run,
    input  logic              doze_mode,
    input  logic              doze_pause,
    input  logic              ovf_clear,
    input  logic              ovf_irq_en,
    output logic [CNT_W-1:0]  count,
    output logic              ovf_flag,
    output logic              ovf_irq
);
    logic [1:0] mode_q;
    logic       cnt_tick;
    logic       advance;
    logic       restart;
    logic       trig_level;
    logic       trig_edge;

    // Register the clock mode; the registered copy is also the readback.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 2'd0;
        else        mode_q <= clk_mode;
    end

    assign clk_mode_rb = mode_q;

    tbase_clk_src #(
        .PS_W        (PS_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_clk_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_q     (mode_q),
        .prescale   (prescale),
        .ext_clk_in (ext_clk_in),
        .advance    (advance),
        .restart    (restart),
        .cnt_tick   (cnt_tick)
    );

    tbase_trig_cond #(
        .N_TRIG      (N_TRIG),
        .SEL_W       (SEL_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_trig_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_in    (trig_in),
        .trig_sel   (trig_sel),
        .active_low (trig_active_low),
        .trig_level (trig_level),
        .trig_edge  (trig_edge)
    );

    tbase_count_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_q         (mode_q),
        .modulo         (modulo),
        .cnt_tick       (cnt_tick),
        .trig_level     (trig_level),
        .trig_edge      (trig_edge),
        .start_on_trig  (start_on_trig),
        .reload_on_trig (reload_on_trig),
        .pause_on_trig  (pause_on_trig),
        .stop_on_ovf    (stop_on_ovf),
        .dbg_mode       (dbg_mode),
        .dbg_run        (dbg_run),
        .doze_mode      (doze_mode),
        .doze_pause     (doze_pause),
        .ovf_clear      (ovf_clear),
        .ovf_irq_en     (ovf_irq_en),
        .advance        (advance),
        .restart        (restart),
        .count          (count),
        .ovf_flag       (ovf_flag),
        .ovf_irq        (ovf_irq)
    );

endmodule

// File: rtl/trig_timebase_chk.sv
// Property checker for the timebase, attached to every instance by bind.
// Assumes clk_mode is held at 0 during reset.
module trig_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       clk_mode,
    input logic [1:0]       clk_mode_rb,
    input logic [CNT_W-1:0] modulo,
    input logic [CNT_W-1:0] count,
    input logic             ovf_flag,
    input logic             ovf_clear,
    input logic             ovf_irq,
    input logic             ovf_irq_en
);
    // R1: readback follows the mode input one edge later
    a_r1_mode_readback: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> clk_mode_rb == $past(clk_mode));

    // R1: a stopped counter holds its value
    a_r1_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_mode_rb == 2'd0 || clk_mode_rb == 2'd3) |=> $stable(count));

    // R4: once inside the range, the count stays at or below the modulo
    a_r4_within_modulo: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(modulo) && $past(count) <= $past(modulo)) |-> count <= modulo);

    // R4: the count steps by one or returns to zero
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + CNT_W'(1)) || (count == '0));

    // R5: the flag rises only together with a wrap to zero
    a_r5_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> count == '0);

    // R5: the flag holds until cleared
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf_flag) && !$past(ovf_clear)) |-> ovf_flag);

    // R5: a masked interrupt stays low
    a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_irq_en |-> !ovf_irq);

endmodule

bind trig_timebase trig_timebase_chk #(.CNT_W(CNT_W)) u_tbase_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_mode    (clk_mode),
    .clk_mode_rb (clk_mode_rb),
    .modulo      (modulo),
    .count       (count),
    .ovf_flag    (ovf_flag),
    .ovf_clear   (ovf_clear),
    .ovf_irq     (ovf_irq),
    .ovf_irq_en  (ovf_irq_en)
);

// File: tb/trig_timebase_bench.sv
module trig_timebase_bench;
    localparam int CNT_W = 16;
    localparam int N_TRIG = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        clk_mode;
    logic [1:0]        clk_mode_rb;
    logic [2:0]        prescale;
    logic [CNT_W-1:0]  modulo;
    logic              ext_clk_in;
    logic [N_TRIG-1:0] trig_in;
    logic [1:0]        trig_sel;
    logic              trig_active_low, start_on_trig, reload_on_trig, pause_on_trig;
    logic              stop_on_ovf, dbg_mode, dbg_run, doze_mode, doze_pause;
    logic              ovf_clear, ovf_irq_en;
    logic [CNT_W-1:0]  count;
    logic              ovf_flag, ovf_irq;

    int     n_checks = 0;
    int     n_errors = 0;
    longint cyc = 0;
    bit     ext_run = 1'b0;
    bit     done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    trig_timebase u_trig_timebase (
        .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode), .clk_mode_rb(clk_mode_rb),
        .prescale(prescale), .modulo(modulo), .ext_clk_in(ext_clk_in),
        .trig_in(trig_in), .trig_sel(trig_sel), .trig_active_low(trig_active_low),
        .start_on_trig(start_on_trig), .reload_on_trig(reload_on_trig),
        .pause_on_trig(pause_on_trig), .stop_on_ovf(stop_on_ovf),
        .dbg_mode(dbg_mode), .dbg_run(dbg_run), .doze_mode(doze_mode),
        .doze_pause(doze_pause), .ovf_clear(ovf_clear), .ovf_irq_en(ovf_irq_en),
        .count(count), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
    );

    // External clock: toggles every 4 cycles, one rising edge per 8 cycles.
    initial begin
        int ph;
        ph = 0;
        ext_clk_in = 1'b0;
        forever begin
            @(negedge clk);
            if (ext_run) begin
                ph++;
                if (ph == 4) begin
                    ph = 0;
                    ext_clk_in = ~ext_clk_in;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic longint exp_period(input int m, input int ps, input int src_div);
        return longint'(m + 1) * (longint'(1) << ps) * src_div;
    endfunction

    task automatic wait_wrap(output longint t);
        int prev;
        prev = int'(count);
        t = -1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (prev != 0 && count == 0) begin
                t = cyc;
                return;
            end
            prev = int'(count);
        end
    endtask

    task automatic measure_period(output longint p);
        longint a, b, c;
        wait_wrap(a);
        wait_wrap(b);
        wait_wrap(c);
        if (a < 0 || b < 0 || c < 0) p = -1;
        else p = c - b;
    endtask

    task automatic restart_mode(input logic [1:0] m);
        clk_mode = 2'd0;
        cycles(2);
        clk_mode = m;
    endtask

    task automatic pulse_trig(input int idx);
        trig_in[idx] = 1'b1;
        cycles(3);
        trig_in[idx] = 1'b0;
    endtask

    // Watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        longint p;
        int c0, m, ps, seed;
        seed = $urandom(32'd1234);
        rst_n = 1'b0; clk_mode = 2'd0; prescale = 3'd0; modulo = 16'd10;
        trig_in = '0; trig_sel = 2'd0; trig_active_low = 1'b0;
        start_on_trig = 1'b0; reload_on_trig = 1'b0; pause_on_trig = 1'b0;
        stop_on_ovf = 1'b0; dbg_mode = 1'b0; dbg_run = 1'b0;
        doze_mode = 1'b0; doze_pause = 1'b0; ovf_clear = 1'b0; ovf_irq_en = 1'b0;
        cycles(5);
        rst_n = 1'b1;
        cycles(1);

        // Reset state
        check(count == 0, "R4 reset count", count, 0);
        check(ovf_flag == 0, "R5 reset flag", ovf_flag, 0);
        check(clk_mode_rb == 0, "R1 reset readback", clk_mode_rb, 0);

        // R1: readback and reserved mode
        clk_mode = 2'd3;
        cycles(1);
        check(clk_mode_rb == 3, "R1 readback", clk_mode_rb, 3);
        c0 = int'(count);
        cycles(10);
        check(int'(count) == c0, "R1 reserved mode holds", count, c0);
        clk_mode = 2'd0;
        cycles(1);
        check(clk_mode_rb == 0, "R1 stop confirmed", clk_mode_rb, 0);

        // R2/R4: random modulo and prescale, system clock
        for (int it = 0; it < 6; it++) begin
            m  = 1 + int'($urandom % 12);
            ps = int'($urandom % 4);
            modulo = CNT_W'(m); prescale = 3'(ps);
            restart_mode(2'd1);
            measure_period(p);
            check(p == exp_period(m, ps, 1), "R2 wrap period", p, exp_period(m, ps, 1));
            check(int'(count) <= m, "R4 count within modulo", count, m);
        end
        // Directed: divide-by-128 corner
        modulo = 16'd1; prescale = 3'd7;
        restart_mode(2'd1);
        measure_period(p);
        check(p == exp_period(1, 7, 1), "R2 divide by 128", p, exp_period(1, 7, 1));
        check(ovf_flag == 1, "R4 wrap sets flag", ovf_flag, 1);

        // R3: external clock
        ext_run = 1'b1;
        modulo = 16'd3; prescale = 3'd1;
        restart_mode(2'd2);
        measure_period(p);
        check(p == exp_period(3, 1, 8), "R3 external period", p, exp_period(3, 1, 8));
        modulo = 16'd4; prescale = 3'd0;
        restart_mode(2'd2);
        measure_period(p);
        check(p == exp_period(4, 0, 8), "R3 external no prescale", p, exp_period(4, 0, 8));
        ext_run = 1'b0;

        // R5: flag, mask and clear
        clk_mode = 2'd0;
        cycles(2);
        ovf_irq_en = 1'b1;
        cycles(1);
        check(ovf_irq == 1, "R5 irq enabled", ovf_irq, 1);
        ovf_irq_en = 1'b0;
        cycles(1);
        check(ovf_irq == 0, "R5 irq masked", ovf_irq, 0);
        check(ovf_flag == 1, "R5 flag sticky", ovf_flag, 1);
        ovf_clear = 1'b1;
        cycles(1);
        ovf_clear = 1'b0;
        check(ovf_flag == 0, "R5 flag cleared", ovf_flag, 0);

        // R6: start on trigger
        modulo = 16'd1000; prescale = 3'd0; start_on_trig = 1'b1;
        restart_mode(2'd1);
        c0 = int'(count);
        cycles(30);
        check(int'(count) == c0, "R6 idle before trigger", count, c0);
        pulse_trig(0);
        cycles(10);
        check(int'(count) != c0, "R6 runs after trigger", count, c0 + 1);
        start_on_trig = 1'b0;

        // R7: reload on trigger
        restart_mode(2'd1);
        reload_on_trig = 1'b1;
        cycles(50);
        check(count >= 40, "R7 counting before reload", count, 40);
        trig_in[0] = 1'b1;
        cycles(3);
        check(count == 0, "R7 reload to zero", count, 0);
        cycles(1);
        check(count == 1, "R7 resumes after reload", count, 1);
        trig_in[0] = 1'b0;
        cycles(4);

        // R9: unselected trigger ignored
        trig_sel = 2'd1;
        cycles(4);
        c0 = int'(count);
        trig_in[0] = 1'b1;
        cycles(6);
        check(int'(count) == c0 + 6, "R9 other trigger ignored", count, c0 + 6);
        trig_in[0] = 1'b0;
        pulse_trig(1);
        check(count == 0, "R9 selected trigger reloads", count, 0);
        reload_on_trig = 1'b0;
        cycles(4);

        // R8: pause while trigger held
        pause_on_trig = 1'b1;
        trig_in[1] = 1'b1;
        cycles(4);
        c0 = int'(count);
        cycles(10);
        check(int'(count) == c0, "R8 paused by trigger", count, c0);
        trig_in[1] = 1'b0;
        cycles(4);
        check(int'(count) != c0, "R8 resumes on release", count, c0 + 1);

        // R9: active-low polarity
        trig_in = '1; trig_active_low = 1'b1;
        cycles(4);
        c0 = int'(count);
        cycles(5);
        check(int'(count) == c0 + 5, "R9 high level inactive when active-low", count, c0 + 5);
        trig_in[1] = 1'b0;
        cycles(4);
        c0 = int'(count);
        cycles(10);
        check(int'(count) == c0, "R9 low level pauses when active-low", count, c0);
        trig_in = '0; trig_active_low = 1'b0; pause_on_trig = 1'b0;
        cycles(4);

        // R10: stop on overflow
        clk_mode = 2'd0;
        modulo = 16'd5; stop_on_ovf = 1'b1;
        cycles(2);
        ovf_clear = 1'b1;
        cycles(1);
        ovf_clear = 1'b0;
        clk_mode = 2'd1;
        for (int i = 0; i < 200 && !ovf_flag; i++) cycles(1);
        check(ovf_flag == 1, "R10 overflow reached", ovf_flag, 1);
        cycles(20);
        check(count == 0, "R10 halted at zero", count, 0);
        check(clk_mode_rb == 1, "R10 mode still set", clk_mode_rb, 1);
        restart_mode(2'd1);
        cycles(5);
        check(count != 0, "R10 runs after mode cycle", count, 1);
        stop_on_ovf = 1'b0;

        // R11: debug pause
        restart_mode(2'd1);
        modulo = 16'd1000;
        cycles(4);
        dbg_mode = 1'b1; dbg_run = 1'b0;
        c0 = int'(count);
        cycles(10);
        check(int'(count) == c0, "R11 paused in debug", count, c0);
        dbg_run = 1'b1;
        cycles(10);
        check(int'(count) == c0 + 10, "R11 runs in debug when allowed", count, c0 + 10);
        dbg_mode = 1'b0; dbg_run = 1'b0;

        // R12: doze pause
        doze_mode = 1'b1; doze_pause = 1'b0;
        c0 = int'(count);
        cycles(10);
        check(int'(count) == c0 + 10, "R12 runs in doze", count, c0 + 10);
        doze_pause = 1'b1;
        c0 = int'(count);
        cycles(10);
        check(int'(count) == c0, "R12 paused in doze", count, c0);
        doze_mode = 1'b0; doze_pause = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule